// File: doc/BRIEF.md
# SDMA Block-Transfer Engine

This block is the data-moving part of an SD host controller that uses single-address DMA. Software programs five things through a small register port: a start address in system memory, a block size, a DMA boundary code, a block count and a transfer mode. It then starts the transfer by writing the mode register with the DMA enable bit set. The engine moves one byte per handshake. In the read direction, bytes go from the card-side input stream to the memory port. In the write direction, bytes go from the memory port to the card-side output stream. The memory address advances by one after each byte.

Software can set a DMA buffer boundary between 4 KiB and 512 KiB. When the next address lands on a multiple of that boundary and the transfer still has bytes left, the engine halts and raises a DMA interrupt status bit. It resumes only when software writes the system address register again. It continues from the written address. When the last byte of the last block has moved, the engine raises transfer-complete status and returns to idle. Both status bits are write-1-to-clear. Each one is gated by its own status-enable bit.

Top module: `sdma_xfer_ctrl`

## Requirements
- R1: After reset every register reads zero (offsets 0 to 6), and no memory or card handshake is offered.
- R2: Mode bit 4 selects the direction. When it is 1, card input bytes are written to memory (mem_we high). When it is 0, memory read data is sent on the card output. The memory address starts at the system address (offset 0) and increases by one per byte moved, and offset 0 reads back the current address.
- R3: With mode bit 5 (multi-block) at 0, exactly one block of the size in offset 1 bits [11:0] is moved, whatever offset 2 holds, and offset 2 is left unchanged.
- R4: With mode bit 5 and mode bit 1 (count enable) both set, the number of blocks in offset 2 is moved, and offset 2 counts down by one per finished block, reaching zero.
- R5: Offset 1 bits [14:12] hold a boundary code C, and the boundary is 4096 << C bytes. After a byte moves, if more bytes remain and the next address is a multiple of the boundary, data movement halts and status bit 3 (DMA interrupt) sets. Offset 0 then reads that next address.
- R6: While halted, a write to offset 0 resumes the transfer from the written address.
- R7: Status bit 1 (transfer complete) sets once the last byte has moved, and the engine returns to idle. A transfer whose final byte ends exactly on a boundary sets no DMA interrupt.
- R8: Status at offset 5 is write-1-to-clear. Writing a 0 to a bit leaves it unchanged.
- R9: Offset 6 holds status enables at the same bit positions (1 and 3). A status bit is never set while its enable is 0, yet the transfer still runs and halts as usual.
- R10: A transfer starts only when the mode register (offset 3) is written with bit 0 set while the engine is idle, the DMA select field at offset 4 bits [4:3] is 00, and the block size is nonzero. Otherwise no byte moves.
- R11: Writes to offsets 1, 2, 3 and 4 are ignored while a transfer is running or halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access (read data valid in the same cycle) |
| mem_we | output | 1 | 1 = write memory, 0 = read memory |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write to memory |
| mem_rdata | input | 8 | Byte read from memory |
| card_in_valid | input | 1 | Card-side byte available |
| card_in_ready | output | 1 | Engine takes the card-side byte |
| card_in_data | input | 8 | Card-side input byte |
| card_out_valid | output | 1 | Byte offered to the card side |
| card_out_ready | input | 1 | Card side takes the byte |
| card_out_data | output | 8 | Card-side output byte |

## Verification
A wrong byte or block counter shows up as extra or missing memory accesses. The scoreboard sees the extra access at the very next handshake, or sees an unfinished queue when completion status arrives too early. A wrong address register shows up as a mismatched mem_addr on the first byte after the fault, or after a resume. A bad boundary decision shows up within one byte: the engine either keeps moving past the boundary or stops short of it. Status or state errors are caught when the status and address registers are read back right after each completion or halt.

// File: rtl/sdma_xfer_pkg.sv
package sdma_xfer_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_RUN   = 2'd1,
        XS_PAUSE = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic multi;
        logic dir_rd;
        logic acmd12;
        logic cnt_en;
        logic dma_en;
    } mode_t;

    // register offsets
    localparam logic [2:0] OFS_SYSADDR = 3'd0;
    localparam logic [2:0] OFS_BLKSIZE = 3'd1;
    localparam logic [2:0] OFS_BLKCNT  = 3'd2;
    localparam logic [2:0] OFS_MODE    = 3'd3;
    localparam logic [2:0] OFS_HOSTCTL = 3'd4;
    localparam logic [2:0] OFS_STATUS  = 3'd5;
    localparam logic [2:0] OFS_STSEN   = 3'd6;

    // bit positions
    localparam int MB_DMA_EN  = 0;
    localparam int MB_CNT_EN  = 1;
    localparam int MB_ACMD12  = 2;
    localparam int MB_DIR_RD  = 4;
    localparam int MB_MULTI   = 5;
    localparam int HC_SEL_LSB = 3;
    localparam int SB_DONE    = 1;
    localparam int SB_DMA     = 3;

    localparam logic [1:0] SEL_SDMA = 2'b00;

endpackage

// File: rtl/sdma_bnd_det.sv
module sdma_bnd_det #(
    parameter int ADDR_W  = 32,
    parameter int CODE_W  = 3,
    parameter int BASE_LG = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              hit_o
);
    localparam int NCODE = 1 << CODE_W;

    logic [NCODE-1:0] hits;

    for (genvar c = 0; c < NCODE; c++) begin : g_code
        localparam int LG = BASE_LG + c;
        if (LG < ADDR_W) begin : g_part
            assign hits[c] = (addr_i[LG-1:0] == '0);
        end else begin : g_full
            assign hits[c] = (addr_i == '0);
        end
    end

    assign hit_o = hits[code_i];
endmodule

// File: rtl/sdma_byte_mover.sv
module sdma_byte_mover #(
    parameter int DATA_W = 8
) (
    input  logic              run_i,
    input  logic              dir_rd_i,
    input  logic              card_in_valid_i,
    input  logic [DATA_W-1:0] card_in_data_i,
    output logic              card_in_ready_o,
    input  logic              card_out_ready_i,
    output logic              card_out_valid_o,
    output logic [DATA_W-1:0] card_out_data_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_valid_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              fire_o
);
    // memory request needs the partner side ready to source or sink the byte
    assign mem_valid_o      = run_i & (dir_rd_i ? card_in_valid_i : card_out_ready_i);
    assign mem_we_o         = dir_rd_i;
    assign mem_wdata_o      = card_in_data_i;
    assign card_in_ready_o  = run_i & dir_rd_i & mem_ready_i;
    assign card_out_valid_o = run_i & ~dir_rd_i & mem_ready_i;
    assign card_out_data_o  = mem_rdata_i;
    assign fire_o           = mem_valid_o & mem_ready_i;
endmodule

// File: rtl/sdma_xfer_ctrl.sv
module sdma_xfer_ctrl
    import sdma_xfer_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 12,
    parameter int CNT_W   = 16,
    parameter int CODE_W  = 3,
    parameter int BASE_LG = 12,
    parameter int DATA_W  = 8,
    parameter int REG_AW  = 3,
    parameter int REG_DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              card_in_valid,
    output logic              card_in_ready,
    input  logic [DATA_W-1:0] card_in_data,
    output logic              card_out_valid,
    input  logic              card_out_ready,
    output logic [DATA_W-1:0] card_out_data
);
    localparam int SIZE_FLD = SIZE_W + CODE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] blk_size;
        logic [CODE_W-1:0] bnd_code;
        logic [CNT_W-1:0]  blk_cnt;
        mode_t             mode;
        logic [1:0]        dma_sel;
        logic              sts_done;
        logic              sts_dma;
        logic              en_done;
        logic              en_dma;
        xfer_st_e          st;
        logic [SIZE_W-1:0] byte_idx;
    } state_t;

    state_t state_d, state_q;

    logic              fire;
    logic              bnd_hit;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = state_q.addr + ADDR_W'(1);

    sdma_bnd_det #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W),
        .BASE_LG(BASE_LG)
    ) bnd_i (
        .addr_i(next_addr),
        .code_i(state_q.bnd_code),
        .hit_o (bnd_hit)
    );

    sdma_byte_mover #(
        .DATA_W(DATA_W)
    ) mover_i (
        .run_i           (state_q.st == XS_RUN),
        .dir_rd_i        (state_q.mode.dir_rd),
        .card_in_valid_i (card_in_valid),
        .card_in_data_i  (card_in_data),
        .card_in_ready_o (card_in_ready),
        .card_out_ready_i(card_out_ready),
        .card_out_valid_o(card_out_valid),
        .card_out_data_o (card_out_data),
        .mem_ready_i     (mem_ready),
        .mem_rdata_i     (mem_rdata),
        .mem_valid_o     (mem_valid),
        .mem_we_o        (mem_we),
        .mem_wdata_o     (mem_wdata),
        .fire_o          (fire)
    );

    assign mem_addr = state_q.addr;

    logic wr_addr, wr_size, wr_cnt, wr_mode, wr_hctl, wr_sts, wr_en;
    logic idle, start, last_blk, blk_end;

    always_comb begin
        state_d = state_q;

        wr_addr = reg_we && (reg_addr == OFS_SYSADDR);
        wr_size = reg_we && (reg_addr == OFS_BLKSIZE);
        wr_cnt  = reg_we && (reg_addr == OFS_BLKCNT);
        wr_mode = reg_we && (reg_addr == OFS_MODE);
        wr_hctl = reg_we && (reg_addr == OFS_HOSTCTL);
        wr_sts  = reg_we && (reg_addr == OFS_STATUS);
        wr_en   = reg_we && (reg_addr == OFS_STSEN);
        idle    = (state_q.st == XS_IDLE);

        // software writes
        if (wr_addr) state_d.addr = reg_wdata[ADDR_W-1:0];
        if (idle) begin
            if (wr_size) begin
                state_d.blk_size = reg_wdata[SIZE_W-1:0];
                state_d.bnd_code = reg_wdata[SIZE_FLD-1:SIZE_W];
            end
            if (wr_cnt)  state_d.blk_cnt = reg_wdata[CNT_W-1:0];
            if (wr_hctl) state_d.dma_sel = reg_wdata[HC_SEL_LSB+1:HC_SEL_LSB];
            if (wr_mode) begin
                state_d.mode.dma_en = reg_wdata[MB_DMA_EN];
                state_d.mode.cnt_en = reg_wdata[MB_CNT_EN];
                state_d.mode.acmd12 = reg_wdata[MB_ACMD12];
                state_d.mode.dir_rd = reg_wdata[MB_DIR_RD];
                state_d.mode.multi  = reg_wdata[MB_MULTI];
            end
        end
        if (wr_en) begin
            state_d.en_done = reg_wdata[SB_DONE];
            state_d.en_dma  = reg_wdata[SB_DMA];
        end
        if (wr_sts) begin
            if (reg_wdata[SB_DONE]) state_d.sts_done = 1'b0;
            if (reg_wdata[SB_DMA])  state_d.sts_dma  = 1'b0;
        end

        // start
        start = idle && wr_mode && reg_wdata[MB_DMA_EN]
                && (state_q.dma_sel == SEL_SDMA)
                && (state_q.blk_size != '0)
                && !(reg_wdata[MB_MULTI] && reg_wdata[MB_CNT_EN]
                     && (state_q.blk_cnt == '0));
        if (start) begin
            state_d.st       = XS_RUN;
            state_d.byte_idx = '0;
        end

        // byte movement
        blk_end  = (state_q.byte_idx == state_q.blk_size - SIZE_W'(1));
        last_blk = !state_q.mode.multi
                   || (state_q.mode.cnt_en && (state_q.blk_cnt == CNT_W'(1)));
        if ((state_q.st == XS_RUN) && fire) begin
            if (!wr_addr) state_d.addr = next_addr;
            if (blk_end) begin
                state_d.byte_idx = '0;
                if (state_q.mode.multi && state_q.mode.cnt_en)
                    state_d.blk_cnt = state_q.blk_cnt - CNT_W'(1);
            end else begin
                state_d.byte_idx = state_q.byte_idx + SIZE_W'(1);
            end
            if (blk_end && last_blk) begin
                state_d.st = XS_IDLE;
                if (state_q.en_done) state_d.sts_done = 1'b1;
            end else if (bnd_hit) begin
                state_d.st = XS_PAUSE;
                if (state_q.en_dma) state_d.sts_dma = 1'b1;
            end
        end

        // resume on address rewrite
        if ((state_q.st == XS_PAUSE) && wr_addr) state_d.st = XS_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_SYSADDR: reg_rdata = REG_DW'(state_q.addr);
            OFS_BLKSIZE: reg_rdata = REG_DW'({state_q.bnd_code, state_q.blk_size});
            OFS_BLKCNT:  reg_rdata = REG_DW'(state_q.blk_cnt);
            OFS_MODE: begin
                reg_rdata[MB_DMA_EN] = state_q.mode.dma_en;
                reg_rdata[MB_CNT_EN] = state_q.mode.cnt_en;
                reg_rdata[MB_ACMD12] = state_q.mode.acmd12;
                reg_rdata[MB_DIR_RD] = state_q.mode.dir_rd;
                reg_rdata[MB_MULTI]  = state_q.mode.multi;
            end
            OFS_HOSTCTL: reg_rdata[HC_SEL_LSB+1:HC_SEL_LSB] = state_q.dma_sel;
            OFS_STATUS: begin
                reg_rdata[SB_DONE] = state_q.sts_done;
                reg_rdata[SB_DMA]  = state_q.sts_dma;
            end
            OFS_STSEN: begin
                reg_rdata[SB_DONE] = state_q.en_done;
                reg_rdata[SB_DMA]  = state_q.en_dma;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdma_xfer_ctrl_chk.sv
module sdma_xfer_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              mem_valid_i,
    input logic              mem_ready_i,
    input logic [ADDR_W-1:0] mem_addr_i,
    input logic              addr_wr_i,
    input logic              size_wr_i,
    input logic              run_i,
    input logic              idle_i,
    input logic              sts_done_i,
    input logic              sts_dma_i,
    input logic              en_dma_i,
    input logic [SIZE_W-1:0] blk_size_i
);
    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && mem_valid_i && mem_ready_i && !addr_wr_i)
        |=> (mem_addr_i == $past(mem_addr_i) + ADDR_W'(1))); // R2

    AST_HALT_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !mem_valid_i); // R5

    AST_DMA_STS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_dma_i) |-> $past(en_dma_i)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_done_i) |-> idle_i); // R7

    AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idle_i && size_wr_i) |=> $stable(blk_size_i)); // R11
endmodule

bind sdma_xfer_ctrl sdma_xfer_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W)
) chk_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mem_valid_i(mem_valid),
    .mem_ready_i(mem_ready),
    .mem_addr_i (mem_addr),
    .addr_wr_i  (wr_addr),
    .size_wr_i  (wr_size),
    .run_i      (state_q.st == XS_RUN),
    .idle_i     (state_q.st == XS_IDLE),
    .sts_done_i (state_q.sts_done),
    .sts_dma_i  (state_q.sts_dma),
    .en_dma_i   (state_q.en_dma),
    .blk_size_i (state_q.blk_size)
);

// File: tb/sdma_xfer_ctrl_tb_top.sv
module sdma_xfer_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        card_in_valid = 1'b1;
    logic        card_in_ready;
    logic [7:0]  card_in_data;
    logic        card_out_valid;
    logic        card_out_ready = 1'b1;
    logic [7:0]  card_out_data;

    logic        stall_en = 1'b0;
    logic        stall_tgl = 1'b0;
    logic [7:0]  card_seq = '0;
    logic [7:0]  exp_seq = '0;
    int          n_run = 0;
    int          n_fail = 0;
    string       cur_req = "R2";

    typedef struct {
        logic        to_mem;
        logic [31:0] addr;
        logic [7:0]  data;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) stall_tgl <= ~stall_tgl;
    assign mem_ready    = !stall_en || stall_tgl;
    assign mem_rdata    = mem_addr[7:0] ^ 8'hA5;
    assign card_in_data = card_seq;

    sdma_xfer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .card_in_valid(card_in_valid), .card_in_ready(card_in_ready), .card_in_data(card_in_data),
        .card_out_valid(card_out_valid), .card_out_ready(card_out_ready), .card_out_data(card_out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected bytes as the design moves them
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL %s: unexpected byte at %h expected none", cur_req, mem_addr);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(cur_req, {31'd0, mem_we}, {31'd0, it.to_mem});
                chk(cur_req, mem_addr, it.addr);
                if (it.to_mem) chk(cur_req, {24'd0, mem_wdata}, {24'd0, it.data});
                else           chk(cur_req, {24'd0, card_out_data}, {24'd0, it.data});
            end
            if (mem_we) card_seq <= card_seq + 8'd1;
        end
    end

    task automatic push_rd(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{1'b1, base + 32'(i), exp_seq});
            exp_seq = exp_seq + 8'd1;
        end
    endtask

    task automatic push_wr(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            a = base + 32'(i);
            exp_q.push_back('{1'b0, a, a[7:0] ^ 8'hA5});
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_bit(input int b, input string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(3'd5, v);
            if (v[b]) return;
        end
        chk(req, 32'hDEAD, 32'(1 << b));
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 7; a++) begin
            reg_rd(3'(a), v);
            chk("R1", v, 32'd0);
        end
        chk("R1", {31'd0, mem_valid}, 32'd0);

        reg_wr(3'd6, 32'h0A);

        // R2/R3: single-block read, count ignored
        cur_req = "R2";
        reg_wr(3'd0, 32'h100);
        reg_wr(3'd1, (32'd7 << 12) | 32'd8);
        reg_wr(3'd2, 32'd5);
        push_rd(32'h100, 8);
        reg_wr(3'd3, 32'h13);
        wait_bit(1, "R7");
        idle_cycles(6);
        chk("R3", 32'(exp_q.size()), 32'd0);
        reg_rd(3'd2, v); chk("R3", v, 32'd5);
        reg_rd(3'd0, v); chk("R2", v, 32'h108);
        reg_rd(3'd5, v); chk("R7", v, 32'h2);
        reg_wr(3'd5, 32'h0);
        reg_rd(3'd5, v); chk("R8", v, 32'h2);
        reg_wr(3'd5, 32'h2);
        reg_rd(3'd5, v); chk("R8", v, 32'h0);

        // R4: multi-block write with stalls
        cur_req = "R4";
        stall_en = 1'b1;
        reg_wr(3'd0, 32'h2000);
        reg_wr(3'd1, (32'd7 << 12) | 32'd4);
        reg_wr(3'd2, 32'd3);
        push_wr(32'h2000, 12);
        reg_wr(3'd3, 32'h23);
        wait_bit(1, "R4");
        idle_cycles(6);
        chk("R4", 32'(exp_q.size()), 32'd0);
        reg_rd(3'd2, v); chk("R4", v, 32'd0);
        reg_rd(3'd0, v); chk("R2", v, 32'h200C);
        reg_wr(3'd5, 32'h2);
        stall_en = 1'b0;

        // R5/R6: halt at 4 KiB boundary then resume elsewhere
        cur_req = "R5";
        reg_wr(3'd0, 32'h0FFC);
        reg_wr(3'd1, 32'd8);
        push_rd(32'h0FFC, 4);
        reg_wr(3'd3, 32'h11);
        wait_bit(3, "R5");
        idle_cycles(10);
        reg_rd(3'd5, v); chk("R5", v, 32'h8);
        reg_rd(3'd0, v); chk("R5", v, 32'h1000);
        chk("R5", {31'd0, mem_valid}, 32'd0);
        chk("R5", 32'(exp_q.size()), 32'd0);
        reg_wr(3'd5, 32'h8);
        cur_req = "R6";
        push_rd(32'h3000, 4);
        reg_wr(3'd0, 32'h3000);
        wait_bit(1, "R6");
        idle_cycles(4);
        chk("R6", 32'(exp_q.size()), 32'd0);
        reg_rd(3'd0, v); chk("R6", v, 32'h3004);
        reg_rd(3'd5, v); chk("R6", v, 32'h2);
        reg_wr(3'd5, 32'hA);

        // R5: code 1 does not stop at 0x1000
        cur_req = "R5";
        reg_wr(3'd0, 32'h0FFE);
        reg_wr(3'd1, (32'd1 << 12) | 32'd4);
        push_rd(32'h0FFE, 4);
        reg_wr(3'd3, 32'h11);
        wait_bit(1, "R5");
        reg_rd(3'd5, v); chk("R5", v, 32'h2);
        reg_rd(3'd0, v); chk("R5", v, 32'h1002);
        reg_wr(3'd5, 32'hA);

        // R7: last byte ends on a boundary
        cur_req = "R7";
        reg_wr(3'd0, 32'h1FFC);
        reg_wr(3'd1, 32'd4);
        push_rd(32'h1FFC, 4);
        reg_wr(3'd3, 32'h11);
        wait_bit(1, "R7");
        idle_cycles(4);
        reg_rd(3'd5, v); chk("R7", v, 32'h2);
        reg_rd(3'd0, v); chk("R7", v, 32'h2000);
        reg_wr(3'd5, 32'hA);

        // R9: enables off
        cur_req = "R9";
        reg_wr(3'd6, 32'h0);
        reg_wr(3'd0, 32'h400);
        push_rd(32'h400, 4);
        reg_wr(3'd3, 32'h11);
        idle_cycles(30);
        chk("R9", 32'(exp_q.size()), 32'd0);
        reg_rd(3'd5, v); chk("R9", v, 32'h0);
        reg_wr(3'd0, 32'h0FFE);
        push_rd(32'h0FFE, 2);
        reg_wr(3'd3, 32'h11);
        idle_cycles(20);
        reg_rd(3'd0, v); chk("R9", v, 32'h1000);
        reg_rd(3'd5, v); chk("R9", v, 32'h0);
        push_rd(32'h5000, 2);
        reg_wr(3'd0, 32'h5000);
        idle_cycles(20);
        chk("R9", 32'(exp_q.size()), 32'd0);
        reg_rd(3'd0, v); chk("R9", v, 32'h5002);
        reg_wr(3'd6, 32'hA);

        // R10: start conditions
        cur_req = "R10";
        reg_wr(3'd4, 32'h10);
        reg_rd(3'd4, v); chk("R10", v, 32'h10);
        reg_wr(3'd0, 32'h600);
        reg_wr(3'd3, 32'h11);
        idle_cycles(20);
        reg_rd(3'd0, v); chk("R10", v, 32'h600);
        reg_rd(3'd5, v); chk("R10", v, 32'h0);
        reg_wr(3'd4, 32'h0);
        reg_wr(3'd3, 32'h10);
        idle_cycles(20);
        reg_rd(3'd0, v); chk("R10", v, 32'h600);
        reg_wr(3'd1, 32'h0);
        reg_wr(3'd3, 32'h11);
        idle_cycles(20);
        reg_rd(3'd0, v); chk("R10", v, 32'h600);

        // R11: config locked while busy
        cur_req = "R11";
        stall_en = 1'b1;
        reg_wr(3'd0, 32'h700);
        reg_wr(3'd1, 32'd16);
        push_rd(32'h700, 16);
        reg_wr(3'd3, 32'h11);
        reg_wr(3'd1, 32'h5);
        reg_wr(3'd2, 32'd9);
        wait_bit(1, "R11");
        idle_cycles(4);
        chk("R11", 32'(exp_q.size()), 32'd0);
        reg_rd(3'd1, v); chk("R11", v, 32'd16);
        reg_rd(3'd2, v); chk("R11", v, 32'd0);
        stall_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule